// File: doc/BRIEF.md
# Serial Flash Status Register Guard

This block keeps the status byte of a serial NOR flash and decides, for every decoded instruction, whether that instruction may proceed. A front end that has already shifted in and decoded the opcode presents one instruction per cycle on `cmdValid`/`cmdOp`, along with a data byte for status writes and a target sector number for program and sector erase. One cycle later the block answers with exactly one of `cmdAccept` or `cmdReject`. It also keeps the busy flag that the rest of the device reads while an array operation runs.

An instruction that changes anything is refused unless the write enable latch is set. It is also refused while a previous cycle is still busy. Program and sector erase are refused when their sector lies inside the protected window. That window is chosen by a 3-bit size code and a top/bottom selector. Bulk erase is refused whenever the size code is nonzero. When the SRWD bit is set and the write-protect pin is held low, status writes are refused. The protection bits model non-volatile storage: they keep their value through `rstN` and are cleared only by `porN`.

An accepted status write, program or erase raises the busy bit. The busy bit lasts either a fixed number of cycles or until the array reports completion, as a parameter selects. When the busy bit drops, the write enable latch clears.

Top module: `flash_status_guard`

## Requirements
- R1: `statusByte` holds SRWD in bit 7, a constant 0 in bit 6, TB in bit 5, the protect size code in bits 4:2, WEL in bit 1 and WIP in bit 0. `porN` low clears the whole byte. `rstN` low clears WEL and WIP and leaves SRWD, TB and the size code unchanged.
- R2: Opcodes are 0 none, 1 set-enable, 2 clear-enable, 3 status write, 4 program, 5 sector erase, 6 bulk erase, 7 status read. Each `cmdValid` cycle yields exactly one of `cmdAccept`/`cmdReject` in the following cycle. Opcode 0 is always rejected. Status read is always accepted and changes nothing.
- R3: An accepted set-enable sets WEL and an accepted clear-enable clears it. Both are rejected while WIP is 1.
- R4: While WEL is 0, status write, program, sector erase and bulk erase are rejected.
- R5: In counted mode (`USE_DONE`=0), an accepted status write, program or erase holds WIP at 1 for exactly `BUSY_CYCLES` cycles, starting in the cycle of its accept pulse. While WIP is 1, every opcode except status read is rejected.
- R6: In done mode (`USE_DONE`=1), WIP stays 1 until `arrayDone` is sampled high and falls at that same clock edge.
- R7: WEL is 0 once WIP falls after an accepted cycle.
- R8: An accepted status write loads data bits 7, 5 and 4:2 into SRWD, TB and the size code. Data bits 6, 1 and 0 have no effect.
- R9: While SRWD is 1 and `wpPinN` is 0, status write is rejected and SRWD, TB and the size code keep their value. With `wpPinN` at 1, the status write is allowed even when SRWD is 1.
- R10: A nonzero size code n protects min(2^(n-1), 2^SECTOR_BITS) sectors. With TB=0 these are the highest-numbered sectors; with TB=1 they start at sector 0. Program and sector erase to a protected sector are rejected, and to any other sector are accepted (given WEL=1, WIP=0).
- R11: Bulk erase is accepted only when the size code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset of WEL, WIP and handshake, active low |
| porN | input | 1 | Synchronous power-on clear of all status bits, active low |
| cmdValid | input | 1 | A decoded instruction is present this cycle |
| cmdOp | input | 3 | Opcode (see R2) |
| cmdData | input | 8 | Data byte for status write |
| cmdSector | input | SECTOR_BITS | Target sector for program and sector erase |
| wpPinN | input | 1 | Write-protect pin level, low protects |
| arrayDone | input | 1 | Completion pulse from the array (done mode) |
| statusByte | output | 8 | Status byte for readback |
| cmdAccept | output | 1 | Instruction of the previous cycle accepted |
| cmdReject | output | 1 | Instruction of the previous cycle rejected |
| busy | output | 1 | Write/program/erase cycle in progress |

## Verification
The bench sweeps every size code against both TB settings and all 32 sectors. This exposes an off-by-one at the window edge, a reversed top/bottom choice, or a failure to cap codes 6 and 7 at the whole array. Any of these would accept a program that should be refused, or refuse a legal one. It counts busy cycles exactly, so a counter that runs one cycle too long or too short is caught. It probes set-enable and clear-enable during busy, which a design that gates only writes on WIP would wrongly accept. It checks the hardware lock with the pin in both states and confirms that a refused write leaves the bits unchanged. It also checks that `rstN` preserves the protection bits, which a design resetting every bit would lose.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WEN    = 3'd1,
    OP_WDIS   = 3'd2,
    OP_WSTAT  = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_RSTAT  = 3'd7
  } fsgOp_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStatus;
  } fsgStrobe_t;
endpackage

// File: rtl/fsg_region.sv
module fsg_region #(
  parameter int SECTOR_BITS = 5
) (
  input  logic [2:0]             bpCode,
  input  logic                   fromBottom,
  input  logic [SECTOR_BITS-1:0] sector,
  output logic                   hit
);
  localparam int NUM = 1 << SECTOR_BITS;
  localparam int CW  = SECTOR_BITS + 1;

  logic [CW-1:0] span;
  logic [CW-1:0] sectorWide;

  assign sectorWide = {1'b0, sector};

  // number of protected sectors, saturating at the whole array
  always_comb begin
    span = '0;
    if (bpCode != 3'd0) begin
      if (int'(bpCode) - 1 >= SECTOR_BITS) span = CW'(NUM);
      else span = CW'(1) << (bpCode - 3'd1);
    end
  end

  always_comb begin
    if (fromBottom) hit = (sectorWide < span);
    else            hit = (sectorWide >= (CW'(NUM) - span));
  end
endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter int SECTOR_BITS = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   porN,
  input  fsgStrobe_t             strb,
  input  logic [7:0]             wrData,
  input  logic                   wipIn,
  input  logic [SECTOR_BITS-1:0] sector,
  input  logic                   wpPinN,
  output logic [7:0]             statusByte,
  output logic                   wel,
  output logic                   hwLocked,
  output logic                   bpZero,
  output logic                   regionHit
);
  logic       srwd;
  logic       topBottom;
  logic [2:0] bpCode;
  logic       unusedData;

  assign unusedData = ^{wrData[6], wrData[1:0]};

  // non-volatile bits: only power-on clears them
  always_ff @(posedge clk) begin
    if (!porN) begin
      srwd      <= 1'b0;
      topBottom <= 1'b0;
      bpCode    <= 3'd0;
    end else if (strb.loadStatus) begin
      srwd      <= wrData[7];
      topBottom <= wrData[5];
      bpCode    <= wrData[4:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !porN)   wel <= 1'b0;
    else if (strb.clrWel) wel <= 1'b0;
    else if (strb.setWel) wel <= 1'b1;
  end

  assign hwLocked   = srwd && !wpPinN;
  assign bpZero     = (bpCode == 3'd0);
  assign statusByte = {srwd, 1'b0, topBottom, bpCode, wel, wipIn};

  fsg_region #(.SECTOR_BITS(SECTOR_BITS)) u_region (
    .bpCode    (bpCode),
    .fromBottom(topBottom),
    .sector    (sector),
    .hit       (regionHit)
  );

  // R7: enable latch is down once the busy cycle ends
  a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rstN || !porN)
    $fell(wipIn) |-> !wel);

  // R9: a locked register keeps its protection bits
  a_r9_locked_stable: assert property (@(posedge clk) disable iff (!rstN || !porN)
    hwLocked |=> $stable({srwd, topBottom, bpCode}));
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter bit USE_DONE    = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porN,
  input  logic       cmdValid,
  input  fsgOp_e     cmdOp,
  input  logic       wel,
  input  logic       hwLocked,
  input  logic       bpZero,
  input  logic       regionHit,
  input  logic       arrayDone,
  output fsgStrobe_t strb,
  output logic       wip,
  output logic       cmdAccept,
  output logic       cmdReject
);
  localparam int CNTW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

  logic [CNTW-1:0] cnt;
  logic            allow;
  logic            take;
  logic            isWrite;
  logic            finish;

  always_comb begin
    isWrite = 1'b0;
    case (cmdOp)
      OP_NONE:            allow = 1'b0;
      OP_WEN, OP_WDIS:    allow = !wip;
      OP_RSTAT:           allow = 1'b1;
      OP_WSTAT: begin
        isWrite = 1'b1;
        allow   = !wip && wel && !hwLocked;
      end
      OP_PROG, OP_SERASE: begin
        isWrite = 1'b1;
        allow   = !wip && wel && !regionHit;
      end
      OP_BERASE: begin
        isWrite = 1'b1;
        allow   = !wip && wel && bpZero;
      end
      default:            allow = 1'b0;
    endcase
  end

  assign take   = cmdValid && allow;
  assign finish = wip && (USE_DONE ? arrayDone : (cnt == '0));

  always_comb begin
    strb.setWel     = take && (cmdOp == OP_WEN);
    strb.clrWel     = (take && (cmdOp == OP_WDIS)) || finish;
    strb.loadStatus = take && (cmdOp == OP_WSTAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !porN) begin
      wip <= 1'b0;
      cnt <= '0;
    end else if (take && isWrite) begin
      wip <= 1'b1;
      cnt <= CNTW'(BUSY_CYCLES - 1);
    end else if (finish) begin
      wip <= 1'b0;
    end else if (wip && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !porN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      cmdAccept <= take;
      cmdReject <= cmdValid && !allow;
    end
  end

  // R2: one answer per instruction
  a_r2_one_answer: assert property (@(posedge clk) disable iff (!rstN || !porN)
    cmdValid |=> (cmdAccept != cmdReject));
  // R4: no enable latch, no write
  a_r4_wel_gate: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && isWrite && !wel) |=> cmdReject);
  // R5: busy refuses everything but a status read
  a_r5_busy_refuse: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && wip && cmdOp != OP_RSTAT) |=> cmdReject);
  // R9: hardware lock refuses status writes
  a_r9_hw_lock: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && cmdOp == OP_WSTAT && hwLocked) |=> cmdReject);
  // R11: bulk erase needs an empty protect code
  a_r11_bulk_gate: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cmdValid && cmdOp == OP_BERASE && !bpZero) |=> cmdReject);
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int SECTOR_BITS = 5,
  parameter int BUSY_CYCLES = 8,
  parameter bit USE_DONE    = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   porN,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic [7:0]             cmdData,
  input  logic [SECTOR_BITS-1:0] cmdSector,
  input  logic                   wpPinN,
  input  logic                   arrayDone,
  output logic [7:0]             statusByte,
  output logic                   cmdAccept,
  output logic                   cmdReject,
  output logic                   busy
);
  fsgStrobe_t strb;
  logic       wip;
  logic       wel;
  logic       hwLocked;
  logic       bpZero;
  logic       regionHit;

  fsg_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .USE_DONE(USE_DONE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .porN     (porN),
    .cmdValid (cmdValid),
    .cmdOp    (fsgOp_e'(cmdOp)),
    .wel      (wel),
    .hwLocked (hwLocked),
    .bpZero   (bpZero),
    .regionHit(regionHit),
    .arrayDone(arrayDone),
    .strb     (strb),
    .wip      (wip),
    .cmdAccept(cmdAccept),
    .cmdReject(cmdReject)
  );

  fsg_datapath #(.SECTOR_BITS(SECTOR_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .porN      (porN),
    .strb      (strb),
    .wrData    (cmdData),
    .wipIn     (wip),
    .sector    (cmdSector),
    .wpPinN    (wpPinN),
    .statusByte(statusByte),
    .wel       (wel),
    .hwLocked  (hwLocked),
    .bpZero    (bpZero),
    .regionHit (regionHit)
  );

  assign busy = wip;
endmodule

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;
  localparam int SB = 5;
  localparam int NSEC = 1 << SB;

  localparam logic [2:0] NONE = 3'd0, WEN = 3'd1, WDIS = 3'd2, WSTAT = 3'd3,
                         PROG = 3'd4, SERASE = 3'd5, BERASE = 3'd6, RSTAT = 3'd7;

  logic clk = 1'b0;
  logic rstN, porN, cmdValid, wpPinN, arrayDone;
  logic [2:0] cmdOp;
  logic [7:0] cmdData;
  logic [SB-1:0] cmdSector;
  logic [7:0] statusByte, statusD;
  logic cmdAccept, cmdReject, busy, accD, rejD, busyD;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_guard #(.SECTOR_BITS(SB), .BUSY_CYCLES(BUSY), .USE_DONE(1'b0)) i_flash_status_guard (
    .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdSector(cmdSector), .wpPinN(wpPinN), .arrayDone(arrayDone),
    .statusByte(statusByte), .cmdAccept(cmdAccept), .cmdReject(cmdReject), .busy(busy));

  flash_status_guard #(.SECTOR_BITS(SB), .BUSY_CYCLES(BUSY), .USE_DONE(1'b1)) i_flash_status_guard_done (
    .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdSector(cmdSector), .wpPinN(wpPinN), .arrayDone(arrayDone),
    .statusByte(statusD), .cmdAccept(accD), .cmdReject(rejD), .busy(busyD));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one instruction; returns at the negedge where the answer is visible
  task automatic issue(input logic [2:0] op, input logic [7:0] d, input int sec, output logic acc);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdSector = SB'(sec);
    @(negedge clk);
    cmdValid = 1'b0;
    acc = cmdAccept;
    if (cmdAccept == cmdReject) begin
      checks++; errors++;
      $display("FAIL R2: accept=%0b reject=%0b expected exactly one", cmdAccept, cmdReject);
    end
  endtask

  task automatic waitIdle();
    while (statusByte[0]) @(negedge clk);
  endtask

  task automatic setStatus(input logic [7:0] d);
    logic a;
    issue(WEN, 8'h00, 0, a);
    issue(WSTAT, d, 0, a);
    waitIdle();
  endtask

  function automatic bit isProt(input int code, input int tb, input int sec);
    int span;
    span = (code == 0) ? 0 : ((code - 1 >= SB) ? NSEC : (1 << (code - 1)));
    return tb ? (sec < span) : (sec >= NSEC - span);
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic a;
    int n;
    rstN = 0; porN = 0; cmdValid = 0; cmdOp = NONE; cmdData = 0; cmdSector = 0;
    wpPinN = 1; arrayDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1; porN = 1;
    @(negedge clk);
    check(statusByte == 8'h00, "R1 power-on status", statusByte, 8'h00);
    check(busy == 1'b0, "R1 power-on busy", busy, 0);

    // R2: empty opcode rejected, status read accepted without effect
    issue(NONE, 8'hFF, 0, a);
    check(!a && cmdReject, "R2 opcode 0 rejected", a, 0);
    issue(RSTAT, 8'hFF, 0, a);
    check(a, "R2 status read accepted", a, 1);
    check(statusByte == 8'h00, "R2 status read no effect", statusByte, 8'h00);

    // R4: everything that writes is refused without WEL
    issue(WSTAT, 8'hFF, 0, a); check(!a, "R4 status write without WEL", a, 0);
    issue(PROG, 0, 3, a);      check(!a, "R4 program without WEL", a, 0);
    issue(SERASE, 0, 3, a);    check(!a, "R4 sector erase without WEL", a, 0);
    issue(BERASE, 0, 0, a);    check(!a, "R4 bulk erase without WEL", a, 0);
    check(statusByte == 8'h00, "R4 nothing changed", statusByte, 8'h00);

    // R3: latch set and clear
    issue(WEN, 0, 0, a);
    check(a && statusByte[1], "R3 set-enable", statusByte[1], 1);
    issue(WDIS, 0, 0, a);
    check(a && !statusByte[1], "R3 clear-enable", statusByte[1], 0);

    // R5/R7: exact busy length and latch drop
    issue(WEN, 0, 0, a);
    issue(BERASE, 0, 0, a);
    check(a, "R11 bulk erase with code 0", a, 1);
    n = 0;
    while (statusByte[0]) begin n++; @(negedge clk); end
    check(n == BUSY, "R5 busy length", n, BUSY);
    check(!statusByte[1], "R7 WEL cleared at end", statusByte[1], 0);

    // R5/R3: refusals while busy
    issue(WEN, 0, 0, a);
    issue(PROG, 0, 0, a);
    issue(WEN, 0, 0, a);  check(!a, "R3 set-enable during busy", a, 0);
    issue(RSTAT, 0, 0, a); check(a, "R5 status read during busy", a, 1);
    issue(WDIS, 0, 0, a); check(!a, "R3 clear-enable during busy", a, 0);
    check(statusByte[1], "R3 WEL unchanged during busy", statusByte[1], 1);
    waitIdle();

    // R8: field loading, ignored bits
    issue(WEN, 0, 0, a);
    issue(WSTAT, 8'hFF, 0, a);
    check(statusByte == 8'hBF, "R8 load all fields", statusByte, 8'hBF);
    waitIdle();
    check(statusByte == 8'hBC, "R8 after completion", statusByte, 8'hBC);
    setStatus(8'h43);
    check(statusByte == 8'h00, "R8 bits 6,1,0 ignored", statusByte, 8'h00);

    // R1: rstN keeps the protection bits
    setStatus(8'hA4);
    issue(WEN, 0, 0, a);
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    check(statusByte == 8'hA4, "R1 rstN preserves protection bits", statusByte, 8'hA4);

    // R9: hardware lock
    setStatus(8'h80);
    wpPinN = 0;
    issue(WEN, 0, 0, a);
    issue(WSTAT, 8'h3C, 0, a);
    check(!a, "R9 locked write rejected", a, 0);
    check(statusByte == 8'h82, "R9 bits kept", statusByte, 8'h82);
    issue(WDIS, 0, 0, a);
    wpPinN = 1;
    issue(WEN, 0, 0, a);
    issue(WSTAT, 8'h00, 0, a);
    check(a, "R9 write allowed with pin high", a, 1);
    waitIdle();
    check(statusByte == 8'h00, "R9 unlocked write applied", statusByte, 8'h00);

    // R11: bulk erase against every code
    for (int c = 1; c < 8; c++) begin
      setStatus(8'(c << 2));
      issue(WEN, 0, 0, a);
      issue(BERASE, 0, 0, a);
      check(!a, $sformatf("R11 bulk erase code %0d", c), a, 0);
    end

    // R10: every code, both ends, every sector
    for (int tb = 0; tb < 2; tb++) begin
      for (int c = 0; c < 8; c++) begin
        setStatus(8'((tb << 5) | (c << 2)));
        for (int s = 0; s < NSEC; s++) begin
          issue(WEN, 0, 0, a);
          issue((s % 2) ? SERASE : PROG, 0, s, a);
          check(a == !isProt(c, tb, s),
                $sformatf("R10 tb=%0d code=%0d sector=%0d", tb, c, s), a, !isProt(c, tb, s));
          waitIdle();
        end
      end
    end

    // R6: done-driven busy
    @(negedge clk); rstN = 0; porN = 0; @(negedge clk); rstN = 1; porN = 1;
    issue(WEN, 0, 0, a);
    issue(BERASE, 0, 0, a);
    check(accD, "R6 done mode accept", accD, 1);
    repeat (3 * BUSY) @(negedge clk);
    check(busyD, "R6 still busy without done", busyD, 1);
    arrayDone = 1'b1;
    @(negedge clk);
    arrayDone = 1'b0;
    check(!statusD[0], "R6 WIP falls on done", statusD[0], 0);
    check(!statusD[1], "R7 WEL cleared in done mode", statusD[1], 0);

    finishRun();
  end
endmodule